// File: doc/BRIEF.md
# Carry-Flag Arithmetic and Shift Unit

This unit is the datapath of a small two-register core. Each cycle it takes the two working registers (called A and B here), the current carry flag, a 5-bit operation code and a 3-bit immediate shift length. One clock later it presents new values for A and B, the new carry and a carry-write strobe. The instruction sequencer writes A and B back from the outputs. It updates its flag only when the strobe is high.

The operations are increment and decrement, add and subtract, the four two-input bitwise functions, single-register inversion, and shifts and rotates. A shift or rotate takes its distance either from the immediate field or from register B. There is also an unsigned multiply that spreads the 16-bit product over both registers. An unsigned divide returns the quotient in A and the remainder in B. Divide by zero gives a fixed, documented result. The divider is an unrolled restoring array, so every operation has the same latency.

The carry has a meaning that depends on the operation. After increment or decrement it means "result is zero". After subtract it means "B was greater than A". After a register-controlled shift it means "A is now zero". After divide it flags a zero divisor.

Top module: `flag_alu`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are `a_out=0`, `b_out=0`, `c_out=0` and `c_we=0`.
- R2: Codes 1/2 increment A/B and codes 3/4 decrement A/B, wrapping modulo 256. `c_we=1`, and `c_out` is 1 exactly when the result is zero. The other register passes through unchanged.
- R3: Code 5 (add) puts A+B mod 256 in A and leaves B unchanged. `c_we=1`, and `c_out` is 1 when the 9-bit sum exceeds 0xFF.
- R4: Code 6 (subtract) puts A−B mod 256 in A and leaves B unchanged. `c_we=1`, and `c_out` is 1 when B>A.
- R5: Codes 7, 8, 9 and 10 write A&B, A|B, A^B and ~(A^B) into A and leave B unchanged. `c_we=0`, and `c_out` equals `carry_in`.
- R6: Code 11 inverts A only and code 12 inverts B only. `c_we=0`, and `c_out` equals `carry_in`.
- R7: Codes 13–20 shift by `imm_len` (0 to 7). The codes are, in order: logical right A, logical right B, logical left A, logical left B, rotate right A, rotate right B, rotate left A, rotate left B. Only the selected register changes, zeros fill logical shifts, and a length of 0 passes the value through. `c_we=0`, and `c_out` equals `carry_in`.
- R8: Codes 21, 22, 23 and 24 act on A by the distance held in B. The codes are logical right, logical left, rotate right and rotate left. A distance of 8 or more makes A zero for both shifts and rotates. A distance of 0 passes A through. B is unchanged. `c_we=1`, and `c_out` is 1 exactly when the new A is zero.
- R9: Code 25 (multiply) forms the 16-bit unsigned product A×B. It writes the high byte to A and the low byte to B, with `c_we=0` and `c_out` equal to `carry_in`.
- R10: Code 26 (divide) with B≠0 writes the unsigned quotient to A and the remainder to B, with `c_we=1` and `c_out=0`. With B=0 it writes A=0xFF and B=0, with `c_we=1` and `c_out=1`.
- R11: Code 0 and the unused codes 27–31 pass A and B through with `c_we=0` and `c_out` equal to `carry_in`.
- R12: The result for the inputs present at one rising clock edge appears on the outputs immediately after that edge and stays until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 5 | Operation code |
| a_in | input | 8 | Current value of register A |
| b_in | input | 8 | Current value of register B |
| carry_in | input | 1 | Current carry flag |
| imm_len | input | 3 | Immediate shift or rotate length |
| a_out | output | 8 | New value for register A |
| b_out | output | 8 | New value for register B |
| c_out | output | 1 | New carry value |
| c_we | output | 1 | Carry-write strobe |

## Verification
The only state in this unit is its output register, so any fault shows up in the one-cycle result of the operation that exposed it. A wrong divider stage corrupts the quotient or remainder for some operand pairs. A shifter fault shows up as filled or lost bits at particular distances. A bad carry decode shows up as a wrong `c_out` or a `c_we` that should have stayed low. The directed cases target the boundaries: wrap at 0xFF and 0x01, borrow at B>A, distances of 0, 7, 8 and 20, and a zero divisor. Sweeps of random operands on add, subtract, multiply and divide catch datapath bit faults within one cycle of the operation that exposes them.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_PASS   = 5'd0,
    OP_INC_A  = 5'd1,
    OP_INC_B  = 5'd2,
    OP_DEC_A  = 5'd3,
    OP_DEC_B  = 5'd4,
    OP_ADD    = 5'd5,
    OP_SUB    = 5'd6,
    OP_AND    = 5'd7,
    OP_OR     = 5'd8,
    OP_XOR    = 5'd9,
    OP_XNOR   = 5'd10,
    OP_NOT_A  = 5'd11,
    OP_NOT_B  = 5'd12,
    OP_SRL_A  = 5'd13,
    OP_SRL_B  = 5'd14,
    OP_SLL_A  = 5'd15,
    OP_SLL_B  = 5'd16,
    OP_ROR_A  = 5'd17,
    OP_ROR_B  = 5'd18,
    OP_ROL_A  = 5'd19,
    OP_ROL_B  = 5'd20,
    OP_VSRL   = 5'd21,
    OP_VSLL   = 5'd22,
    OP_VROR   = 5'd23,
    OP_VROL   = 5'd24,
    OP_MUL    = 5'd25,
    OP_DIV    = 5'd26
  } alu_op_e;
endpackage

// File: rtl/alu_shift.sv
// Barrel shifter/rotator: logical or circular, either direction.
module alu_shift #(
  parameter int W  = 8,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  val,
  input  logic [SW-1:0] amt,
  input  logic          left,
  input  logic          rot,
  output logic [W-1:0]  res
);
  logic [2*W-1:0] dbl_r, dbl_l;
  logic [W-1:0]   res_r, res_l;

  // right: upper half feeds the wrap-around bits; left: lower half does
  assign dbl_r = {rot ? val : {W{1'b0}}, val};
  assign dbl_l = {val, rot ? val : {W{1'b0}}};
  assign res_r = W'(dbl_r >> amt);
  assign res_l = W'((dbl_l << amt) >> W);
  assign res   = left ? res_l : res_r;
endmodule

// File: rtl/alu_div.sv
// Unrolled restoring divider: one trial subtraction per quotient bit.
module alu_div #(
  parameter int W = 8
) (
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem
);
  logic [W-1:0] part [0:W];

  assign part[0] = '0;

  for (genvar k = 0; k < W; k++) begin : g_step
    logic [W:0] shifted;
    logic [W:0] diff;
    assign shifted = {part[k], dividend[W-1-k]};
    assign diff    = shifted - {1'b0, divisor};
    assign quot[W-1-k] = ~diff[W];
    assign part[k+1]   = diff[W] ? shifted[W-1:0] : diff[W-1:0];
  end

  assign rem = part[W];
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import alu_pkg::*;
#(
  parameter int W  = 8,
  parameter int SW = $clog2(W)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    a_in,
  input  logic [W-1:0]    b_in,
  input  logic            carry_in,
  input  logic [SW-1:0]   imm_len,
  output logic [W-1:0]    a_out,
  output logic [W-1:0]    b_out,
  output logic            c_out,
  output logic            c_we
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  alu_op_e op_e;
  assign op_e = alu_op_e'(op);

  // immediate shifter controls
  logic          imm_on_b, imm_left, imm_rot;
  logic [W-1:0]  imm_src, imm_res;
  // register-controlled shifter controls
  logic          var_left, var_rot, var_big;
  logic [W-1:0]  var_res, var_final;
  // multiply / divide
  logic [2*W-1:0] prod;
  logic [W-1:0]   quot, rem;
  // next-state values
  logic [W-1:0]   nxt_a, nxt_b;
  logic [W-1:0]   sum_a, inc_v, dec_v;
  logic           nxt_c, nxt_we, add_cy;

  always_comb begin
    imm_on_b = 1'b0;
    imm_left = 1'b0;
    imm_rot  = 1'b0;
    case (op_e)
      OP_SRL_B: imm_on_b = 1'b1;
      OP_SLL_A: imm_left = 1'b1;
      OP_SLL_B: begin imm_left = 1'b1; imm_on_b = 1'b1; end
      OP_ROR_A: imm_rot  = 1'b1;
      OP_ROR_B: begin imm_rot = 1'b1; imm_on_b = 1'b1; end
      OP_ROL_A: begin imm_rot = 1'b1; imm_left = 1'b1; end
      OP_ROL_B: begin imm_rot = 1'b1; imm_left = 1'b1; imm_on_b = 1'b1; end
      default: ;
    endcase
  end

  assign imm_src  = imm_on_b ? b_in : a_in;
  assign var_left = (op_e == OP_VSLL) || (op_e == OP_VROL);
  assign var_rot  = (op_e == OP_VROR) || (op_e == OP_VROL);
  assign var_big  = 32'(b_in) >= W;

  alu_shift #(.W(W), .SW(SW)) u_imm_shift (
    .val(imm_src), .amt(imm_len), .left(imm_left), .rot(imm_rot), .res(imm_res)
  );

  alu_shift #(.W(W), .SW(SW)) u_var_shift (
    .val(a_in), .amt(b_in[SW-1:0]), .left(var_left), .rot(var_rot), .res(var_res)
  );

  assign var_final = var_big ? '0 : var_res;

  alu_div #(.W(W)) u_div (
    .dividend(a_in), .divisor(b_in), .quot(quot), .rem(rem)
  );

  assign prod           = (2*W)'(a_in) * (2*W)'(b_in);
  assign {add_cy, sum_a} = {1'b0, a_in} + {1'b0, b_in};
  assign inc_v = ((op_e == OP_INC_B) ? b_in : a_in) + 1'b1;
  assign dec_v = ((op_e == OP_DEC_B) ? b_in : a_in) - 1'b1;

  always_comb begin
    nxt_a  = a_in;
    nxt_b  = b_in;
    nxt_c  = carry_in;
    nxt_we = 1'b0;
    case (op_e)
      OP_INC_A: begin nxt_a = inc_v; nxt_we = 1'b1; nxt_c = (inc_v == '0); end
      OP_INC_B: begin nxt_b = inc_v; nxt_we = 1'b1; nxt_c = (inc_v == '0); end
      OP_DEC_A: begin nxt_a = dec_v; nxt_we = 1'b1; nxt_c = (dec_v == '0); end
      OP_DEC_B: begin nxt_b = dec_v; nxt_we = 1'b1; nxt_c = (dec_v == '0); end
      OP_ADD:   begin nxt_a = sum_a; nxt_we = 1'b1; nxt_c = add_cy; end
      OP_SUB:   begin nxt_a = a_in - b_in; nxt_we = 1'b1; nxt_c = (b_in > a_in); end
      OP_AND:   nxt_a = a_in & b_in;
      OP_OR:    nxt_a = a_in | b_in;
      OP_XOR:   nxt_a = a_in ^ b_in;
      OP_XNOR:  nxt_a = ~(a_in ^ b_in);
      OP_NOT_A: nxt_a = ~a_in;
      OP_NOT_B: nxt_b = ~b_in;
      OP_SRL_A, OP_SLL_A, OP_ROR_A, OP_ROL_A: nxt_a = imm_res;
      OP_SRL_B, OP_SLL_B, OP_ROR_B, OP_ROL_B: nxt_b = imm_res;
      OP_VSRL, OP_VSLL, OP_VROR, OP_VROL: begin
        nxt_a  = var_final;
        nxt_we = 1'b1;
        nxt_c  = (var_final == '0);
      end
      OP_MUL:   {nxt_a, nxt_b} = prod;
      OP_DIV: begin
        nxt_we = 1'b1;
        if (b_in == '0) begin
          nxt_a = ALL_ONES;
          nxt_b = '0;
          nxt_c = 1'b1;
        end else begin
          nxt_a = quot;
          nxt_b = rem;
          nxt_c = 1'b0;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_out <= '0;
      b_out <= '0;
      c_out <= 1'b0;
      c_we  <= 1'b0;
    end else begin
      a_out <= nxt_a;
      b_out <= nxt_b;
      c_out <= nxt_c;
      c_we  <= nxt_we;
    end
  end
endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic [OP_W-1:0] op,
  input logic [W-1:0]    a_in,
  input logic [W-1:0]    b_in,
  input logic            carry_in,
  input logic [W-1:0]    a_out,
  input logic [W-1:0]    b_out,
  input logic            c_out,
  input logic            c_we
);
  localparam int MAXV = (1 << W) - 1;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (a_out == '0 && b_out == '0 && !c_out && !c_we));

  // R2
  inc_zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_INC_A) |=> (c_we && a_out == W'($past(a_in) + 1'b1)
                          && c_out == (a_out == '0) && b_out == $past(b_in)));

  // R3
  add_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_ADD) |=> (c_we && b_out == $past(b_in)
      && c_out == ((32'($past(a_in)) + 32'($past(b_in))) > MAXV)));

  // R4
  sub_borrow_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_SUB) |=> (c_we && b_out == $past(b_in)
                        && c_out == ($past(b_in) > $past(a_in))));

  // R5
  logic_keeps_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (op >= OP_AND && op <= OP_XNOR) |=> (!c_we && c_out == $past(carry_in)));

  // R8
  var_far_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (op >= OP_VSRL && op <= OP_VROL && 32'(b_in) >= W)
      |=> (a_out == '0 && c_out && c_we));

  // R9
  mul_split_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_MUL) |=> (!c_we &&
      {a_out, b_out} == (2*W)'($past(a_in)) * (2*W)'($past(b_in))));

  // R10
  div_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_DIV && b_in == '0) |=> (a_out == {W{1'b1}} && b_out == '0 && c_out && c_we));

  // R10
  div_identity_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_DIV && b_in != '0) |=> (c_we && !c_out && b_out < $past(b_in)
      && (2*W)'(a_out) * (2*W)'($past(b_in)) + (2*W)'(b_out) == (2*W)'($past(a_in))));

  // R11
  unused_code_chk: assert property (@(posedge clk) disable iff (rst)
    (op > OP_DIV) |=> (!c_we && a_out == $past(a_in) && b_out == $past(b_in)
                       && c_out == $past(carry_in)));
endmodule

bind flag_alu flag_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .op(op), .a_in(a_in), .b_in(b_in), .carry_in(carry_in),
  .a_out(a_out), .b_out(b_out), .c_out(c_out), .c_we(c_we)
);

// File: tb/sim_flag_alu.sv
module sim_flag_alu;
  import alu_pkg::*;

  typedef struct {
    logic [7:0] a;
    logic [7:0] b;
    logic       c;
    logic       we;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] op = 5'd0;
  logic [7:0] a_in = 8'd0, b_in = 8'd0;
  logic       carry_in = 1'b0;
  logic [2:0] imm_len = 3'd0;
  logic [7:0] a_out, b_out;
  logic       c_out, c_we;

  int n_chk = 0;
  int n_fail = 0;
  exp_t sb[$];

  always #2 clk = ~clk;

  flag_alu u0 (
    .clk(clk), .rst(rst), .op(op), .a_in(a_in), .b_in(b_in), .carry_in(carry_in),
    .imm_len(imm_len), .a_out(a_out), .b_out(b_out), .c_out(c_out), .c_we(c_we)
  );

  function automatic logic [7:0] step_shift(logic [7:0] x, int n, bit left, bit rot);
    logic [7:0] y = x;
    for (int i = 0; i < n; i++) begin
      if (left) y = {y[6:0], rot ? y[7] : 1'b0};
      else      y = {rot ? y[0] : 1'b0, y[7:1]};
    end
    return y;
  endfunction

  function automatic exp_t model(logic [4:0] o, logic [7:0] a, logic [7:0] b,
                                 logic c, logic [2:0] len, string tag);
    exp_t e;
    e.a = a; e.b = b; e.c = c; e.we = 1'b0; e.tag = tag;
    case (o)
      OP_INC_A: begin e.a = a + 8'd1; e.we = 1; e.c = (e.a == 0); end
      OP_INC_B: begin e.b = b + 8'd1; e.we = 1; e.c = (e.b == 0); end
      OP_DEC_A: begin e.a = a - 8'd1; e.we = 1; e.c = (e.a == 0); end
      OP_DEC_B: begin e.b = b - 8'd1; e.we = 1; e.c = (e.b == 0); end
      OP_ADD:   begin e.a = a + b; e.we = 1; e.c = (int'(a) + int'(b) > 255); end
      OP_SUB:   begin e.a = a - b; e.we = 1; e.c = (int'(b) > int'(a)); end
      OP_AND:   e.a = a & b;
      OP_OR:    e.a = a | b;
      OP_XOR:   e.a = a ^ b;
      OP_XNOR:  e.a = ~(a ^ b);
      OP_NOT_A: e.a = ~a;
      OP_NOT_B: e.b = ~b;
      OP_SRL_A: e.a = step_shift(a, int'(len), 0, 0);
      OP_SRL_B: e.b = step_shift(b, int'(len), 0, 0);
      OP_SLL_A: e.a = step_shift(a, int'(len), 1, 0);
      OP_SLL_B: e.b = step_shift(b, int'(len), 1, 0);
      OP_ROR_A: e.a = step_shift(a, int'(len), 0, 1);
      OP_ROR_B: e.b = step_shift(b, int'(len), 0, 1);
      OP_ROL_A: e.a = step_shift(a, int'(len), 1, 1);
      OP_ROL_B: e.b = step_shift(b, int'(len), 1, 1);
      OP_VSRL, OP_VSLL, OP_VROR, OP_VROL: begin
        if (int'(b) >= 8) e.a = 8'd0;
        else e.a = step_shift(a, int'(b), (o == OP_VSLL || o == OP_VROL),
                              (o == OP_VROR || o == OP_VROL));
        e.we = 1; e.c = (e.a == 0);
      end
      OP_MUL: begin
        logic [15:0] p;
        p = 16'(a) * 16'(b);
        e.a = p[15:8]; e.b = p[7:0];
      end
      OP_DIV: begin
        e.we = 1;
        if (b == 0) begin e.a = 8'hFF; e.b = 8'h00; e.c = 1; end
        else begin e.a = a / b; e.b = a % b; e.c = 0; end
      end
      default: ;
    endcase
    return e;
  endfunction

  // driver: present one operation per cycle and queue its expected result
  task automatic drive(logic [4:0] o, logic [7:0] a, logic [7:0] b, logic c,
                       logic [2:0] len, string tag);
    @(negedge clk);
    op = o; a_in = a; b_in = b; carry_in = c; imm_len = len;
    sb.push_back(model(o, a, b, c, len, tag));
  endtask

  // monitor: one cycle after capture the registered result must match (R12)
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        n_chk++;
        if (a_out !== e.a || b_out !== e.b || c_out !== e.c || c_we !== e.we) begin
          n_fail++;
          $display("FAIL %s (R12 one-cycle result): got a=%h b=%h c=%b we=%b expected a=%h b=%h c=%b we=%b",
                   e.tag, a_out, b_out, c_out, c_we, e.a, e.b, e.c, e.we);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got no completion, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    n_chk++;
    if (a_out !== 8'd0 || b_out !== 8'd0 || c_out !== 1'b0 || c_we !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset: got a=%h b=%h c=%b we=%b expected all zero",
               a_out, b_out, c_out, c_we);
    end
    @(negedge clk);
    rst = 1'b0;

    drive(OP_INC_A, 8'd68,  8'h11, 0, 0, "R2 inc A");
    drive(OP_INC_A, 8'hFF,  8'h11, 0, 0, "R2 inc A wrap");
    drive(OP_INC_B, 8'h22,  8'hFF, 0, 0, "R2 inc B wrap");
    drive(OP_DEC_A, 8'd1,   8'h33, 0, 0, "R2 dec A to zero");
    drive(OP_DEC_B, 8'h44,  8'd0,  1, 0, "R2 dec B wrap");
    drive(OP_ADD,   8'h12,  8'h34, 1, 0, "R3 add");
    drive(OP_ADD,   8'hA3,  8'hCB, 0, 0, "R3 add carry");
    drive(OP_ADD,   8'h80,  8'h7F, 1, 0, "R3 add at 0xFF");
    drive(OP_SUB,   8'h50,  8'h10, 1, 0, "R4 sub");
    drive(OP_SUB,   8'h50,  8'h90, 0, 0, "R4 sub borrow");
    drive(OP_SUB,   8'h5A,  8'h5A, 1, 0, "R4 sub equal");
    drive(OP_AND,   8'hB7,  8'h8C, 1, 0, "R5 and");
    drive(OP_OR,    8'hB7,  8'h8C, 0, 0, "R5 or");
    drive(OP_XOR,   8'hB7,  8'h8C, 1, 0, "R5 xor");
    drive(OP_XNOR,  8'hB7,  8'h8C, 1, 0, "R5 xnor");
    drive(OP_NOT_A, 8'hAA,  8'h55, 1, 0, "R6 invert A");
    drive(OP_NOT_B, 8'h55,  8'hAA, 0, 0, "R6 invert B");
    drive(OP_SRL_A, 8'h9D,  8'h01, 1, 3'd2, "R7 srl A");
    drive(OP_SRL_B, 8'h01,  8'h9D, 0, 3'd0, "R7 srl B len0");
    drive(OP_SLL_A, 8'h9D,  8'h01, 0, 3'd2, "R7 sll A");
    drive(OP_SLL_B, 8'h01,  8'h9D, 1, 3'd7, "R7 sll B len7");
    drive(OP_ROR_A, 8'h9D,  8'h01, 0, 3'd2, "R7 ror A");
    drive(OP_ROR_B, 8'h01,  8'h9D, 1, 3'd7, "R7 ror B len7");
    drive(OP_ROL_A, 8'h9D,  8'h01, 1, 3'd2, "R7 rol A");
    drive(OP_ROL_B, 8'h01,  8'h9D, 0, 3'd0, "R7 rol B len0");
    drive(OP_VSRL,  8'h72,  8'd3,  1, 0, "R8 var srl");
    drive(OP_VSLL,  8'h72,  8'd3,  1, 0, "R8 var sll");
    drive(OP_VSRL,  8'h72,  8'd0,  1, 0, "R8 var distance 0");
    drive(OP_VSRL,  8'h72,  8'd20, 0, 0, "R8 var srl far");
    drive(OP_VROR,  8'h9D,  8'd2,  0, 0, "R8 var ror");
    drive(OP_VROL,  8'h9D,  8'd7,  0, 0, "R8 var rol 7");
    drive(OP_VROL,  8'h9D,  8'd8,  0, 0, "R8 var rol 8 zeroes");
    drive(OP_VSLL,  8'h81,  8'd7,  0, 0, "R8 var sll 7");
    drive(OP_MUL,   8'hC2,  8'hA7, 1, 0, "R9 mul");
    drive(OP_MUL,   8'hFF,  8'hFF, 0, 0, "R9 mul max");
    drive(OP_DIV,   8'd200, 8'd7,  1, 0, "R10 div");
    drive(OP_DIV,   8'd5,   8'd9,  1, 0, "R10 div small");
    drive(OP_DIV,   8'h37,  8'd0,  0, 0, "R10 div by zero");
    drive(5'd0,     8'h3C,  8'hC3, 1, 3'd5, "R11 code 0");
    drive(5'd27,    8'h3C,  8'hC3, 0, 3'd5, "R11 code 27");
    drive(5'd31,    8'h3C,  8'hC3, 1, 3'd5, "R11 code 31");

    for (int i = 0; i < 40; i++) begin
      drive(OP_ADD, 8'($urandom), 8'($urandom), 1'($urandom), 0, "R3 sweep");
      drive(OP_SUB, 8'($urandom), 8'($urandom), 1'($urandom), 0, "R4 sweep");
      drive(OP_MUL, 8'($urandom), 8'($urandom), 1'($urandom), 0, "R9 sweep");
      drive(OP_DIV, 8'($urandom), 8'($urandom), 1'($urandom), 0, "R10 sweep");
    end

    @(negedge clk);
    op = 5'd0;
    repeat (3) @(posedge clk);
    #2;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule